// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital control part of a 10-bit successive-approximation analog-to-digital converter in a small microcontroller. Software reaches it over a byte-wide register bus with a two-bit address. A control register selects one of six analog channels and the conversion rate. Writing the control register with its completion flag cleared starts a conversion.

While a conversion runs, the block first spends a fixed number of conversion-clock steps sampling and settling. It then drives a 10-bit trial code to an external comparator and reads back a single-bit answer. It resolves the result one bit per conversion-clock step, from the most significant bit down to the least. At the end it stores the result, sets the completion flag and raises a one-cycle interrupt request.

The result can be read as a packed 8-bit value or as a 10-bit value split across two addresses. The comparator, the resistor ladder and the analog multiplexer are outside this block. The block only drives a one-hot channel select toward them.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, the control register (address 0) reads 0x10, every result address reads 0x00, `irqReq` is 0 and `chanSel` is 000001.
- R2: Control bits 2:0 hold the channel code. Codes 0 to 5 drive `chanSel` one-hot with only bit n set. Codes 6 and 7 drive `chanSel` to all zeros.
- R3: A write to address 0 with bit 4 equal to 0 starts a conversion. Control bit 4 (completion flag) reads 0 while the conversion runs and reads 1 once it ends.
- R4: With control bit 3 = 1 (conversion clock equals the system clock), the completion flag reads 1 exactly 61 system clocks after the clock edge that took the start write, and still reads 0 one clock earlier.
- R5: With control bit 3 = 0 (conversion clock equals half the system clock), the completion flag reads 1 exactly 122 system clocks after the start edge, and still reads 0 one clock earlier.
- R6: The last 10 conversion-clock steps each test one bit, from bit 9 down to bit 0. `trialCode` is the bits kept so far with the tested bit set, and it reads 0 during the settle steps. A bit is kept when `cmpHigh` is 1, so an input level v from 0 to 1023 converts to exactly v.
- R7: `irqReq` is high for exactly one system clock, in the same cycle that the completion flag first reads 1.
- R8: Address 3 reads result bits 9:2. Address 1 reads result bits 7:0. Address 2 reads result bits 9:8 in bits 1:0, with bits 7:2 equal to 0.
- R9: Control bits 7:5 always read 0. A control write with bit 4 = 1 updates bits 3:0 only: it starts nothing, leaves the completion flag at 1 and leaves the result unchanged.
- R10: The result addresses keep returning the previous result until the conversion in progress ends.
- R11: A start write during a running conversion restarts the sequence. Completion then follows 61 (fast) system clocks after the restarting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Register address for read and write |
| busWr | input | 1 | Write strobe, sampled on the rising clock edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |
| chanSel | output | 6 | One-hot analog channel select |
| trialCode | output | 10 | Trial level sent to the reference ladder |
| cmpHigh | input | 1 | Comparator: 1 when the input is at or above the trial level |
| irqReq | output | 1 | One-cycle conversion-complete interrupt request |

## Verification
The bound checker covers the properties that hold on every cycle. These are the zero upper bits of the control and split-high reads, the one-hot or empty channel select, the pairing of the interrupt pulse with the rising completion flag, the pulse being a single cycle, and the result holding still except at a finish strobe. Only the bench scenarios can show the exact 61 and 122 clock conversion lengths, the bit-serial search reaching the correct code against the modelled comparator, the reserved-channel result, and the restart timing. Those checks depend on a counted start edge and on the analog inputs the bench drives.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_LO   = 2'd1,
    ADDR_HI   = 2'd2,
    ADDR_PACK = 2'd3
  } regAddr_t;

  // control -> datapath strobes
  typedef struct packed {
    logic             clrAcc;
    logic             latchBit;
    logic             trialOn;
    logic [IDX_W-1:0] bitIdx;
    logic             finish;
  } sarStrobe_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int RES_BITS   = 10,
  parameter int CONV_STEPS = 61
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWr,
  input  logic       startReq,
  input  logic [2:0] cfgChan,
  input  logic       cfgFast,
  output logic [2:0] chanCode,
  output logic       fastClk,
  output logic       doneFlag,
  output logic       busy,
  output logic       irqReq,
  output sarStrobe_t stb
);
  localparam int SETTLE = CONV_STEPS - RES_BITS;
  localparam int STEP_W = $clog2(CONV_STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CONV_STEPS - 1);

  logic [STEP_W-1:0] stepQ;
  logic phaseQ, busyQ, doneQ, fastQ, irqQ;
  logic [2:0] chanQ;
  logic tick, lastTick, trialOn;
  logic [IDX_W-1:0] bitIdx;

  assign tick     = busyQ & (fastQ | phaseQ);
  assign lastTick = tick & (stepQ == LAST_STEP) & ~startReq;
  assign trialOn  = busyQ & (int'(stepQ) >= SETTLE);

  always_comb begin
    int rel;
    rel    = int'(stepQ) - SETTLE;
    bitIdx = trialOn ? IDX_W'(RES_BITS - 1 - rel) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chanQ  <= '0;
      fastQ  <= 1'b0;
      doneQ  <= 1'b1;
      busyQ  <= 1'b0;
      phaseQ <= 1'b0;
      stepQ  <= '0;
      irqQ   <= 1'b0;
    end else begin
      irqQ <= lastTick;
      if (cfgWr) begin
        chanQ <= cfgChan;
        fastQ <= cfgFast;
      end
      if (startReq) begin
        busyQ  <= 1'b1;
        doneQ  <= 1'b0;
        phaseQ <= 1'b0;
        stepQ  <= '0;
      end else if (busyQ) begin
        phaseQ <= ~phaseQ;
        if (tick) begin
          if (stepQ == LAST_STEP) begin
            busyQ <= 1'b0;
            doneQ <= 1'b1;
          end else begin
            stepQ <= stepQ + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    stb.clrAcc   = startReq;
    stb.latchBit = tick & trialOn & ~startReq;
    stb.trialOn  = trialOn;
    stb.bitIdx   = bitIdx;
    stb.finish   = lastTick;
  end

  assign chanCode = chanQ;
  assign fastClk  = fastQ;
  assign doneFlag = doneQ;
  assign busy     = busyQ;
  assign irqReq   = irqQ;
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  sarStrobe_t          stb,
  input  logic                cmpHigh,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] result
);
  logic [RES_BITS-1:0] accQ, accNext, trialMask, resQ;

  always_comb begin
    trialMask = stb.trialOn ? (RES_BITS'(1) << stb.bitIdx) : '0;
    trialCode = accQ | trialMask;
    accNext   = accQ;
    if (stb.latchBit && cmpHigh) accNext = trialCode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accQ <= '0;
      resQ <= '0;
    end else begin
      if (stb.clrAcc) accQ <= '0;
      else            accQ <= accNext;
      if (stb.finish) resQ <= accNext;
    end
  end

  assign result = resQ;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int RES_BITS   = 10,
  parameter int CONV_STEPS = 61,
  parameter int CHAN_NUM   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          busAddr,
  input  logic                busWr,
  input  logic [7:0]          busWrData,
  output logic [7:0]          busRdData,
  output logic [CHAN_NUM-1:0] chanSel,
  output logic [RES_BITS-1:0] trialCode,
  input  logic                cmpHigh,
  output logic                irqReq
);
  localparam int HI_BITS = RES_BITS - 8;

  logic cfgWr, startReq, fastClk, doneFlag, busy;
  logic [2:0] chanCode;
  logic [RES_BITS-1:0] result;
  sarStrobe_t stb;
  logic unusedWrBits;

  assign unusedWrBits = ^busWrData[7:5];
  assign cfgWr    = busWr & (regAddr_t'(busAddr) == ADDR_CTRL);
  assign startReq = cfgWr & ~busWrData[4];

  sar_ctrl #(.RES_BITS(RES_BITS), .CONV_STEPS(CONV_STEPS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cfgWr(cfgWr), .startReq(startReq),
    .cfgChan(busWrData[2:0]), .cfgFast(busWrData[3]),
    .chanCode(chanCode), .fastClk(fastClk), .doneFlag(doneFlag),
    .busy(busy), .irqReq(irqReq), .stb(stb)
  );

  sar_datapath #(.RES_BITS(RES_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .result(result)
  );

  for (genvar c = 0; c < CHAN_NUM; c++) begin : g_sel
    assign chanSel[c] = (int'(chanCode) == c);
  end

  always_comb begin
    unique case (regAddr_t'(busAddr))
      ADDR_CTRL: busRdData = {3'b000, doneFlag, fastClk, chanCode};
      ADDR_LO:   busRdData = result[7:0];
      ADDR_HI:   busRdData = 8'(result[RES_BITS-1 -: HI_BITS]);
      ADDR_PACK: busRdData = result[RES_BITS-1 -: 8];
      default:   busRdData = '0;
    endcase
  end
endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk #(
  parameter int RES_BITS = 10,
  parameter int CHAN_NUM = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          busAddr,
  input logic [7:0]          busRdData,
  input logic [CHAN_NUM-1:0] chanSel,
  input logic                irqReq,
  input logic                doneFlag,
  input logic                finish,
  input logic [RES_BITS-1:0] result
);
  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == 2'd0) |-> (busRdData[7:5] == 3'b000)); // R9
  AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == 2'd2) |-> (busRdData[7:2] == 6'd0)); // R8
  AST_CHAN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chanSel)); // R2
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> doneFlag); // R7
  AST_DONE_RISE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doneFlag) |-> irqReq); // R7
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |=> !irqReq); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(result)); // R10
endmodule

bind sar_conv_ctrl sar_conv_chk #(.RES_BITS(RES_BITS), .CHAN_NUM(CHAN_NUM)) u_chk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busRdData(busRdData),
  .chanSel(chanSel), .irqReq(irqReq), .doneFlag(doneFlag),
  .finish(stb.finish), .result(result)
);

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] busAddr = '0;
  logic busWr = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [5:0] chanSel;
  logic [9:0] trialCode;
  logic cmpHigh;
  logic irqReq;

  int total = 0;
  int bad = 0;
  bit ended = 0;
  logic [9:0] chVal [6];

  always #4 clk = ~clk;

  sar_conv_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .chanSel(chanSel),
    .trialCode(trialCode), .cmpHigh(cmpHigh), .irqReq(irqReq)
  );

  // analog model: selected input compared against trial level
  always_comb begin
    cmpHigh = 1'b0;
    for (int c = 0; c < 6; c++)
      if (chanSel[c] && chVal[c] >= trialCode) cmpHigh = 1'b1;
  end

  // {chan[2:0], fast, value[9:0]}
  localparam logic [13:0] VEC [7] = '{
    {3'd0, 1'b1, 10'd700},
    {3'd3, 1'b0, 10'd1023},
    {3'd5, 1'b1, 10'd0},
    {3'd1, 1'b1, 10'd513},
    {3'd2, 1'b0, 10'd341},
    {3'd4, 1'b1, 10'd1},
    {3'd6, 1'b1, 10'd999}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    busAddr = a; busWr = 1'b1; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    busAddr = a; #1; d = busRdData;
  endtask

  task automatic checkResult(string req, logic [9:0] exp);
    logic [7:0] d;
    rd(2'd3, d); chk(req, d, 32'(exp[9:2]));
    rd(2'd1, d); chk(req, d, 32'(exp[7:0]));
    rd(2'd2, d); chk(req, d, 32'(exp[9:8]));
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    logic [9:0] prev;
    for (int c = 0; c < 6; c++) chVal[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 32'h10);
    checkResult("R1 result", 10'd0);
    chk("R1 irq", irqReq, 0);
    chk("R1 chanSel", chanSel, 32'h01);

    // vector table walk: R3 R6 R8 R10 R4 R5
    prev = '0;
    for (int i = 0; i < 7; i++) begin
      logic [2:0] ch;
      logic fast;
      logic [9:0] v, exp;
      int len;
      {ch, fast, v} = VEC[i];
      if (ch < 6) chVal[ch] = v;
      exp = (ch < 6) ? v : 10'd0;
      len = fast ? 61 : 122;
      wr(2'd0, {4'b0000, fast, ch});
      rd(2'd0, d); chk("R3 done low", d[4], 0);
      repeat (30) @(negedge clk);
      rd(2'd1, d); chk("R10 prev result", d, 32'(prev[7:0]));
      repeat (len - 31) @(negedge clk);
      rd(2'd0, d); chk(fast ? "R4 not yet" : "R5 not yet", d[4], 0);
      chk("R7 irq early", irqReq, 0);
      @(negedge clk);
      rd(2'd0, d); chk(fast ? "R4 done" : "R5 done", d[4], 1);
      chk("R7 irq", irqReq, 1);
      checkResult(ch < 6 ? "R6 R8 result" : "R2 reserved result", exp);
      @(negedge clk);
      chk("R7 irq one cycle", irqReq, 0);
      prev = exp;
    end

    // R6 trial code sequence (fast mode, channel 0 = 700)
    wr(2'd0, 8'h08);
    repeat (50) @(negedge clk);
    chk("R6 settle trial", trialCode, 0);
    @(negedge clk);
    chk("R6 first trial", trialCode, 32'h200);
    @(negedge clk);
    chk("R6 second trial", trialCode, 32'h300);
    repeat (20) @(negedge clk);
    checkResult("R6 end", 10'd700);

    // R2 channel codes
    for (int c = 0; c < 8; c++) begin
      wr(2'd0, 8'h18 | 8'(c));
      chk("R2 chanSel", chanSel, (c < 6) ? (32'h1 << c) : 32'h0);
    end

    // R9 write with bit 4 set: no start, upper bits zero
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R9 ctrl readback", d, 32'h1F);
    repeat (130) @(negedge clk);
    rd(2'd0, d); chk("R9 still done", d[4], 1);
    checkResult("R9 result kept", 10'd700);

    // R11 restart while busy (fast, channel 1 = 513)
    wr(2'd0, 8'h09);
    repeat (19) @(negedge clk);
    wr(2'd0, 8'h09);
    repeat (60) @(negedge clk);
    rd(2'd0, d); chk("R11 not yet", d[4], 0);
    @(negedge clk);
    rd(2'd0, d); chk("R11 done", d[4], 1);
    chk("R11 irq", irqReq, 1);
    checkResult("R11 result", 10'd513);

    finishRun();
  end
endmodule